// File: doc/BRIEF.md
# PCI Target Read Latency Controller

This block is the target-side state machine that answers PCI memory read bursts on behalf of an application whose read data arrives in a FIFO. When a read is claimed and the FIFO is still empty, the block can take one of two paths. In delayed mode it retries the master at once, so the master comes back later. In nondelayed mode it claims the bus and holds it with wait states while the application fills the FIFO. If the data has not appeared within a selectable initial-latency budget of 16 or 32 clocks, it falls back to a retry.

The application learns of each claimed read through a one-clock request pulse that carries the captured address. Once data flows, the block drives TRDY# on every clock where the FIFO holds a word and the master asserts IRDY#. It pulses a pop strobe for each word moved. If the FIFO runs dry mid-burst, it disconnects the master. Address decoding, parity and the FIFO storage are handled elsewhere.

Top module: `pci_rd_latency_ctl`

## Requirements
- R1: After reset DEVSEL#, TRDY# and STOP# are deasserted (high), and appReq and fifoPop are low.
- R2: Only the memory-read command codes 4'b0110, 4'b1100 and 4'b1110 on cbeN during the address phase (the first clock with FRAME# low after it was high) are claimed. Any other code leaves DEVSEL# high and raises no request.
- R3: For each claimed read, appReq is high for exactly one clock, the clock after the address phase, and appAddr then holds the address sampled in the address phase.
- R4: In delayed mode (nonDelayed = 0), a read claimed with the FIFO empty is retried on the first clock after the address phase: DEVSEL# and STOP# are low and TRDY# is high.
- R5: In either mode, a read claimed with the FIFO non-empty gets TRDY# on the first clock after the address phase, with no wait states.
- R6: In nondelayed mode, DEVSEL# is held low with TRDY# and STOP# high until the FIFO flag is seen. TRDY# first asserts on the clock after the first clock in which the flag is high.
- R7: In nondelayed mode the initial latency limit is 16 clocks when longLatency = 0 and 32 clocks when longLatency = 1. After exactly that many wait clocks without data, STOP# asserts with TRDY# high.
- R8: Data that appears in the last allowed wait clock is still served, with no retry.
- R9: After a retry or disconnect, DEVSEL# and STOP# stay low until a clock in which FRAME# and IRDY# are both high. Both are released on the following clock.
- R10: During the data phases, TRDY# is low only in clocks where the FIFO is non-empty and IRDY# is low. Each such clock moves one word and raises fifoPop.
- R11: If the FIFO is empty during a data phase of the burst, the target disconnects by asserting STOP# with TRDY# high.
- R12: The latency counter restarts at every address phase, so each read receives the full wait budget.
- R13: A burst ends normally when a word is moved with FRAME# high. A four-word burst moves four words and returns DEVSEL# high on the next clock.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | PCI clock |
| rstN | input | 1 | Active-low synchronous reset |
| frameN | input | 1 | FRAME#, active low |
| irdyN | input | 1 | IRDY#, active low |
| cbeN | input | 4 | Command during the address phase |
| adIn | input | ADDR_W | Address during the address phase |
| nonDelayed | input | 1 | 1: hold the bus with wait states; 0: retry at once when no data |
| longLatency | input | 1 | 1: 32-clock initial latency limit; 0: 16-clock limit |
| fifoNotEmpty | input | 1 | Read FIFO holds at least one word |
| devselN | output | 1 | DEVSEL#, active low |
| trdyN | output | 1 | TRDY#, active low |
| stopN | output | 1 | STOP#, active low |
| appReq | output | 1 | One-clock request pulse to the application |
| appAddr | output | ADDR_W | Captured address of the claimed read |
| fifoPop | output | 1 | One word leaves the FIFO this clock |

## Verification
The bench builds the block with its default parameters: a 32-bit address, a 16-clock short latency limit and a 32-clock long one. With these values both retry boundaries are reached within a few dozen clocks per transaction. This lets the bench compare data that arrives on the last allowed wait clock against data that arrives one clock too late, under both limits. It also runs back-to-back reads, so a stale counter would show up as a shortened wait budget.

// File: rtl/pci_rd_pkg.sv
package pci_rd_pkg;

  typedef enum logic [1:0] {
    ST_IDLE,
    ST_WAIT,
    ST_XFER,
    ST_STOP
  } rdState_t;

  typedef struct packed {
    logic loadAddr;
    logic incCnt;
  } ctlStrobe_t;

  localparam logic [3:0] CMD_MEM_RD      = 4'b0110;
  localparam logic [3:0] CMD_MEM_RD_MULT = 4'b1100;
  localparam logic [3:0] CMD_MEM_RD_LINE = 4'b1110;

  function automatic logic isReadCmd(input logic [3:0] code);
    return (code == CMD_MEM_RD) || (code == CMD_MEM_RD_MULT) ||
           (code == CMD_MEM_RD_LINE);
  endfunction

endpackage

// File: rtl/pci_rd_dp.sv
module pci_rd_dp
  import pci_rd_pkg::*;
#(
  parameter int ADDR_W    = 32,
  parameter int LAT_SHORT = 16,
  parameter int LAT_LONG  = 32,
  parameter int CNT_W     = $clog2(LAT_LONG)
) (
  input  logic              clk,
  input  logic              rstN,
  input  logic              frameN,
  input  logic [3:0]        cbeN,
  input  logic [ADDR_W-1:0] adIn,
  input  logic              longLatency,
  input  ctlStrobe_t        strobes,
  output logic              addrPhase,
  output logic              isMemRead,
  output logic              latExpired,
  output logic              appReq,
  output logic [ADDR_W-1:0] appAddr
);

  localparam logic [CNT_W-1:0] LIM_SHORT = CNT_W'(LAT_SHORT - 1);
  localparam logic [CNT_W-1:0] LIM_LONG  = CNT_W'(LAT_LONG - 1);

  logic             prevFrameN;
  logic [CNT_W-1:0] waitCnt;
  logic [CNT_W-1:0] waitLimit;

  always_ff @(posedge clk) begin
    if (!rstN) prevFrameN <= 1'b1;
    else       prevFrameN <= frameN;
  end

  assign addrPhase  = prevFrameN && !frameN;
  assign isMemRead  = isReadCmd(cbeN);
  assign latExpired = (waitCnt == waitLimit);

  always_ff @(posedge clk) begin
    if (!rstN) begin
      waitCnt   <= '0;
      waitLimit <= LIM_SHORT;
      appAddr   <= '0;
      appReq    <= 1'b0;
    end else begin
      appReq <= strobes.loadAddr;
      if (strobes.loadAddr) begin
        appAddr   <= adIn;
        waitCnt   <= '0;
        waitLimit <= longLatency ? LIM_LONG : LIM_SHORT;
      end else if (strobes.incCnt) begin
        waitCnt <= waitCnt + 1'b1;
      end
    end
  end

endmodule

// File: rtl/pci_rd_ctl.sv
module pci_rd_ctl
  import pci_rd_pkg::*;
(
  input  logic       clk,
  input  logic       rstN,
  input  logic       frameN,
  input  logic       irdyN,
  input  logic       nonDelayed,
  input  logic       fifoNotEmpty,
  input  logic       addrPhase,
  input  logic       isMemRead,
  input  logic       latExpired,
  output ctlStrobe_t strobes,
  output logic       devselN,
  output logic       trdyN,
  output logic       stopN,
  output logic       fifoPop
);

  rdState_t state, nextState;
  logic     moveWord;

  assign moveWord = (state == ST_XFER) && fifoNotEmpty && !irdyN;

  always_comb begin
    nextState = state;
    strobes   = '0;
    unique case (state)
      ST_IDLE: begin
        if (addrPhase && isMemRead) begin
          strobes.loadAddr = 1'b1;
          if (fifoNotEmpty)    nextState = ST_XFER;
          else if (nonDelayed) nextState = ST_WAIT;
          else                 nextState = ST_STOP;
        end
      end
      ST_WAIT: begin
        if (fifoNotEmpty)    nextState = ST_XFER;
        else if (latExpired) nextState = ST_STOP;
        else                 strobes.incCnt = 1'b1;
      end
      ST_XFER: begin
        if (!fifoNotEmpty)           nextState = ST_STOP;
        else if (moveWord && frameN) nextState = ST_IDLE;
      end
      ST_STOP: begin
        if (frameN && irdyN) nextState = ST_IDLE;
      end
      default: nextState = ST_IDLE;
    endcase
  end

  always_ff @(posedge clk) begin
    if (!rstN) state <= ST_IDLE;
    else       state <= nextState;
  end

  assign devselN = (state == ST_IDLE);
  assign trdyN   = !moveWord;
  assign stopN   = !((state == ST_STOP) || ((state == ST_XFER) && !fifoNotEmpty));
  assign fifoPop = moveWord;

endmodule

// File: rtl/pci_rd_latency_ctl.sv
module pci_rd_latency_ctl
  import pci_rd_pkg::*;
#(
  parameter int ADDR_W    = 32,
  parameter int LAT_SHORT = 16,
  parameter int LAT_LONG  = 32
) (
  input  logic              clk,
  input  logic              rstN,
  input  logic              frameN,
  input  logic              irdyN,
  input  logic [3:0]        cbeN,
  input  logic [ADDR_W-1:0] adIn,
  input  logic              nonDelayed,
  input  logic              longLatency,
  input  logic              fifoNotEmpty,
  output logic              devselN,
  output logic              trdyN,
  output logic              stopN,
  output logic              appReq,
  output logic [ADDR_W-1:0] appAddr,
  output logic              fifoPop
);

  localparam int CNT_W = $clog2(LAT_LONG);

  ctlStrobe_t strobes;
  logic       addrPhase;
  logic       isMemRead;
  logic       latExpired;

  pci_rd_dp #(
    .ADDR_W(ADDR_W), .LAT_SHORT(LAT_SHORT), .LAT_LONG(LAT_LONG), .CNT_W(CNT_W)
  ) dp_i (
    .clk(clk), .rstN(rstN), .frameN(frameN), .cbeN(cbeN), .adIn(adIn),
    .longLatency(longLatency), .strobes(strobes), .addrPhase(addrPhase),
    .isMemRead(isMemRead), .latExpired(latExpired), .appReq(appReq),
    .appAddr(appAddr)
  );

  pci_rd_ctl ctl_i (
    .clk(clk), .rstN(rstN), .frameN(frameN), .irdyN(irdyN),
    .nonDelayed(nonDelayed), .fifoNotEmpty(fifoNotEmpty),
    .addrPhase(addrPhase), .isMemRead(isMemRead), .latExpired(latExpired),
    .strobes(strobes), .devselN(devselN), .trdyN(trdyN), .stopN(stopN),
    .fifoPop(fifoPop)
  );

endmodule

// File: rtl/pci_rd_checker.sv
module pci_rd_checker
  import pci_rd_pkg::*;
#(
  parameter int LAT_LONG = 32
) (
  input logic       clk,
  input logic       rstN,
  input logic       frameN,
  input logic       irdyN,
  input logic [3:0] cbeN,
  input logic       nonDelayed,
  input logic       fifoNotEmpty,
  input logic       devselN,
  input logic       trdyN,
  input logic       stopN,
  input logic       appReq
);

  int   waitRun;
  logic dataSeen;

  always_ff @(posedge clk) begin
    if (!rstN || devselN) begin
      waitRun  <= 0;
      dataSeen <= 1'b0;
    end else begin
      if (!trdyN) dataSeen <= 1'b1;
      if (trdyN && stopN && !dataSeen) waitRun <= waitRun + 1;
    end
  end

  // R10: a word is only offered with data present and the master ready
  p_trdy_needs_data_r10: assert property (@(posedge clk) disable iff (!rstN)
    !trdyN |-> (fifoNotEmpty && !irdyN && !devselN));

  // R11: STOP# and TRDY# never low together
  p_no_stop_with_trdy_r11: assert property (@(posedge clk) disable iff (!rstN)
    !(!trdyN && !stopN));

  // R9: STOP# held until the bus is released
  p_stop_held_r9: assert property (@(posedge clk) disable iff (!rstN)
    (!stopN && !(frameN && irdyN)) |=> !stopN);

  // R9: release one clock after FRAME# and IRDY# both high
  p_stop_release_r9: assert property (@(posedge clk) disable iff (!rstN)
    (!stopN && frameN && irdyN) |=> (stopN && devselN));

  // R3: request is a single-clock pulse
  p_req_pulse_r3: assert property (@(posedge clk) disable iff (!rstN)
    appReq |=> !appReq);

  // R2: non-read commands are not claimed
  p_no_claim_r2: assert property (@(posedge clk) disable iff (!rstN)
    ($fell(frameN) && devselN && !isReadCmd(cbeN)) |=> (devselN && !appReq));

  // R4: delayed mode with no data retries at once
  p_delayed_retry_r4: assert property (@(posedge clk) disable iff (!rstN)
    ($fell(frameN) && devselN && isReadCmd(cbeN) && !nonDelayed && !fifoNotEmpty)
      |=> (!devselN && !stopN && trdyN));

  // R7: wait states never exceed the long limit
  p_wait_bound_r7: assert property (@(posedge clk) disable iff (!rstN)
    waitRun <= LAT_LONG);

endmodule

bind pci_rd_latency_ctl pci_rd_checker #(.LAT_LONG(LAT_LONG)) chk_i (
  .clk(clk), .rstN(rstN), .frameN(frameN), .irdyN(irdyN), .cbeN(cbeN),
  .nonDelayed(nonDelayed), .fifoNotEmpty(fifoNotEmpty), .devselN(devselN),
  .trdyN(trdyN), .stopN(stopN), .appReq(appReq)
);

// File: tb/pci_rd_latency_ctl_test.sv
module pci_rd_latency_ctl_test;

  logic        clk = 1'b0;
  logic        rstN = 1'b0;
  logic        frameN = 1'b1, irdyN = 1'b1;
  logic [3:0]  cbeN = 4'b0000;
  logic [31:0] adIn = '0;
  logic        nonDelayed = 1'b0, longLatency = 1'b0, fifoNotEmpty = 1'b0;
  logic        devselN, trdyN, stopN, appReq, fifoPop;
  logic [31:0] appAddr;

  int checks = 0, errors = 0;
  bit done = 0;

  // per-transaction observations
  int waits, xfers, firstTrdy, firstStop, reqCnt, reqBad, trdyBad, popBad;
  int relCycle, relDevsel, endCycle;

  always #10 clk = ~clk;

  pci_rd_latency_ctl uut (
    .clk(clk), .rstN(rstN), .frameN(frameN), .irdyN(irdyN), .cbeN(cbeN),
    .adIn(adIn), .nonDelayed(nonDelayed), .longLatency(longLatency),
    .fifoNotEmpty(fifoNotEmpty), .devselN(devselN), .trdyN(trdyN),
    .stopN(stopN), .appReq(appReq), .appAddr(appAddr), .fifoPop(fifoPop)
  );

  task automatic chk(input string req, input int act, input int exp);
    checks++;
    if (act != exp) begin
      errors++;
      $display("FAIL %s: actual %0d expected %0d", req, act, exp);
    end
  endtask

  // One read transaction; dataAt = cycle the FIFO fills (-1 never).
  task automatic runRead(input logic [3:0] cmd, input bit nd, input bit lg,
                         input int dataAt, input int supply, input int words,
                         input int stallAt, input logic [31:0] addr);
    int fifoCount = 0;
    bit stopSeen = 0, released = 0;
    waits = 0; xfers = 0; firstTrdy = -1; firstStop = -1; reqCnt = 0;
    reqBad = 0; trdyBad = 0; popBad = 0; relCycle = -1; relDevsel = -1;
    endCycle = -1;
    @(negedge clk);
    frameN = 1'b0; irdyN = 1'b1; cbeN = cmd; adIn = addr;
    nonDelayed = nd; longLatency = lg;
    if (dataAt == 0) fifoCount = supply;
    fifoNotEmpty = (fifoCount > 0);
    for (int k = 1; k < 120; k++) begin
      @(negedge clk);
      cbeN = 4'b0000; adIn = 32'hDEAD_BEEF;
      if (k == dataAt) fifoCount = supply;
      fifoNotEmpty = (fifoCount > 0);
      if (released) begin
        frameN = 1'b1; irdyN = 1'b1;
      end else if (stopSeen || xfers >= words) begin
        if (frameN || xfers >= words) begin
          frameN = 1'b1; irdyN = 1'b1; released = 1; relCycle = k;
        end else begin
          frameN = 1'b1; irdyN = 1'b0;
        end
      end else begin
        frameN = (xfers >= words - 1);
        irdyN  = (k == stallAt);
      end
      #1;
      if (k == relCycle) relDevsel = devselN;
      if (appReq) begin
        reqCnt++;
        if (k != 1 || appAddr != addr) reqBad++;
      end
      if (!devselN && trdyN && stopN && xfers == 0 && !stopSeen) waits++;
      if (!trdyN && (irdyN || !fifoNotEmpty)) trdyBad++;
      if (fifoPop != (!trdyN && !irdyN)) popBad++;
      if (!trdyN && !irdyN) begin
        xfers++;
        if (firstTrdy < 0) firstTrdy = k;
        fifoCount--;
      end
      if (!stopN) begin
        stopSeen = 1;
        if (firstStop < 0) firstStop = k;
      end
      if (released && devselN) begin
        endCycle = k;
        break;
      end
    end
    @(negedge clk);
    fifoNotEmpty = 1'b0;
  endtask

  task automatic testReset();
    #1;
    chk("R1 devselN", devselN, 1);
    chk("R1 trdyN", trdyN, 1);
    chk("R1 stopN", stopN, 1);
    chk("R1 appReq", appReq, 0);
    chk("R1 fifoPop", fifoPop, 0);
  endtask

  task automatic testIgnoredCmd();
    int claimed = 0, reqs = 0;
    @(negedge clk);
    frameN = 1'b0; irdyN = 1'b1; cbeN = 4'b0111; adIn = 32'h0000_1000;
    fifoNotEmpty = 1'b1;
    for (int k = 1; k < 6; k++) begin
      @(negedge clk);
      frameN = 1'b1; irdyN = (k > 3);
      #1;
      if (!devselN || !trdyN || !stopN) claimed++;
      if (appReq) reqs++;
    end
    chk("R2 write cmd not claimed", claimed, 0);
    chk("R2 write cmd no request", reqs, 0);
    fifoNotEmpty = 1'b0;
  endtask

  task automatic testDelayedRetry();
    runRead(4'b0110, 0, 0, -1, 0, 4, -1, 32'h0000_2000);
    chk("R4 retry on first clock", firstStop, 1);
    chk("R4 no wait states", waits, 0);
    chk("R4 no data moved", xfers, 0);
    chk("R3 one request pulse", reqCnt, 1);
    chk("R3 request timing and address", reqBad, 0);
    chk("R9 held at release clock", relDevsel, 0);
    chk("R9 release next clock", endCycle, relCycle + 1);
  endtask

  task automatic testReadyAtAddr();
    runRead(4'b1100, 0, 0, 0, 4, 4, -1, 32'h0000_3000);
    chk("R5 delayed mode data ready first TRDY", firstTrdy, 1);
    chk("R13 four words moved", xfers, 4);
    chk("R13 no stop", firstStop, -1);
    chk("R13 idle right after last word", endCycle, relCycle);
    chk("R10 pop matches transfer", popBad, 0);
    chk("R2 read multiple claimed", reqCnt, 1);
    runRead(4'b1110, 1, 0, 0, 4, 4, -1, 32'h0000_3100);
    chk("R5 nondelayed data ready first TRDY", firstTrdy, 1);
    chk("R2 read line claimed, four words", xfers, 4);
  endtask

  task automatic testWaitThenData();
    runRead(4'b0110, 1, 0, 5, 4, 4, -1, 32'h0000_4000);
    chk("R6 wait clocks", waits, 5);
    chk("R6 first TRDY after flag", firstTrdy, 6);
    chk("R6 four words", xfers, 4);
    chk("R6 no retry", firstStop, -1);
    chk("R3 address with wait", reqBad, 0);
  endtask

  task automatic testShortExpire();
    runRead(4'b0110, 1, 0, -1, 0, 4, -1, 32'h0000_5000);
    chk("R7 short limit wait clocks", waits, 16);
    chk("R7 short retry clock", firstStop, 17);
    chk("R7 no data", xfers, 0);
    chk("R9 retry held then released", endCycle, relCycle + 1);
  endtask

  task automatic testLongExpire();
    runRead(4'b0110, 1, 1, -1, 0, 4, -1, 32'h0000_6000);
    chk("R7 long limit wait clocks", waits, 32);
    chk("R7 long retry clock", firstStop, 33);
    runRead(4'b0110, 1, 1, 20, 4, 4, -1, 32'h0000_6100);
    chk("R7 long limit serves data at 20", xfers, 4);
    chk("R7 long limit no retry", firstStop, -1);
  endtask

  task automatic testBoundary();
    runRead(4'b0110, 1, 0, 16, 4, 4, -1, 32'h0000_7000);
    chk("R8 data on last wait clock served", xfers, 4);
    chk("R8 no retry", firstStop, -1);
    chk("R8 first TRDY", firstTrdy, 17);
    runRead(4'b0110, 1, 0, 17, 4, 4, -1, 32'h0000_7100);
    chk("R8 data one clock late retried", firstStop, 17);
    chk("R8 late data not moved", xfers, 0);
  endtask

  task automatic testCounterRestart();
    runRead(4'b0110, 1, 0, -1, 0, 4, -1, 32'h0000_8000);
    runRead(4'b0110, 1, 0, -1, 0, 4, -1, 32'h0000_8100);
    chk("R12 second read full budget", waits, 16);
  endtask

  task automatic testStallAndDisconnect();
    runRead(4'b0110, 0, 0, 0, 4, 4, 2, 32'h0000_9000);
    chk("R10 no TRDY without IRDY or data", trdyBad, 0);
    chk("R10 four words across stall", xfers, 4);
    runRead(4'b0110, 1, 0, 3, 2, 4, -1, 32'h0000_9100);
    chk("R11 words before disconnect", xfers, 2);
    chk("R11 disconnect clock", firstStop, 6);
    chk("R11 TRDY only with data", trdyBad, 0);
    chk("R9 disconnect held then released", endCycle, relCycle + 1);
  endtask

  initial begin
    repeat (3) @(negedge clk);
    testReset();
    rstN = 1'b1;
    @(negedge clk);
    testIgnoredCmd();
    testDelayedRetry();
    testReadyAtAddr();
    testWaitThenData();
    testShortExpire();
    testLongExpire();
    testBoundary();
    testCounterRestart();
    testStallAndDisconnect();
    if (!done) begin
      done = 1;
      $display("Simulation finished: %0d checks, %0d errors", checks, errors);
      $finish;
    end
  end

  initial begin
    repeat (20000) @(posedge clk);
    if (!done) begin
      done = 1;
      checks++;
      errors++;
      $display("FAIL watchdog: actual timeout expected completion");
      $display("Simulation finished: %0d checks, %0d errors", checks, errors);
      $finish;
    end
  end

endmodule